// File: doc/BRIEF.md
# Tile Integer Matrix-Multiply Engine

This engine computes the matrix product C = A x B on small integer tiles held in four internal buffers: a left operand tile, a right operand tile, an accumulator tile and a single bias row. Software or a neighbouring block fills the operand buffers through one write port. It then issues a command carrying the run-time valid sizes, and reads the accumulator back through a read port once the command has finished. Operands are 8-bit signed and results are 32-bit signed.

One command port selects among three modes: a fresh product that overwrites the accumulator, a continued product that adds onto the values already there (for split-K loops carried across several commands), and a product with a bias row added, where each bias entry is added down its own output column. A matrix-vector flag marks a command whose left tile has exactly one valid row. The engine checks every command before it starts. An illegal command raises an error pulse and leaves every buffer untouched. A legal command performs one multiply-accumulate per cycle, with K innermost, then N, then M, and pulses done when it is finished.

Top module: `tile_mma_engine`

## Requirements
- R1: Fresh mode (opcode 0) writes C[i][j] = sum over k < K of A[i][k]*B[k][j] for every i < M, j < N.
- R2: Accumulate mode (opcode 1) writes C[i][j] = previous C[i][j] + sum over k of A[i][k]*B[k][j] within the valid region.
- R3: Bias mode (opcode 2) writes C[i][j] = bias[j] + sum over k of A[i][k]*B[k][j]. The bias row is written with select code 3 at column j.
- R4: After acceptance, busy stays high for exactly M*N*K cycles. Done is high for one cycle, in the first cycle after busy falls, and the final result is readable in that cycle.
- R5: When the matrix-vector flag is set, a command with M not equal to 1 is rejected. With M = 1 the command runs as a normal product.
- R6: A command with any of M, K or N equal to 0, or above the tile capacity DIM (16), is rejected.
- R7: A command whose right-tile valid row count differs from K is rejected. Opcode 3 is rejected.
- R8: A rejected command raises err for exactly one cycle, in the cycle after acceptance. Busy stays low and no accumulator element changes.
- R9: Accumulator elements outside the valid M x N region keep their previous values across a run.
- R10: Accumulation wraps modulo 2^32 without saturation. For example, 0x7FFFFFFF plus 1*1 in accumulate mode gives 0x80000000.
- R11: While busy is high, new commands and buffer writes are ignored.
- R12: After reset, busy, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Buffer write strobe (ignored while busy) |
| wrSel | input | 2 | Target buffer: 0 left, 1 right, 2 accumulator, 3 bias row |
| wrRow | input | 4 | Write row index (unused for the bias row) |
| wrCol | input | 4 | Write column index |
| wrData | input | 32 | Write data; operand tiles take the low 8 bits as signed |
| rdRow | input | 4 | Accumulator read row |
| rdCol | input | 4 | Accumulator read column |
| rdData | output | 32 | Accumulator element at rdRow, rdCol (combinational) |
| cmdValid | input | 1 | Command strobe, taken when busy is low |
| cmdOp | input | 2 | 0 fresh, 1 accumulate, 2 bias, 3 illegal |
| cmdGemv | input | 1 | Matrix-vector flag, requires M = 1 |
| cmdM | input | 12 | Valid rows of the left tile |
| cmdK | input | 12 | Valid columns of the left tile |
| cmdKr | input | 12 | Valid rows of the right tile |
| cmdN | input | 12 | Valid columns of the right tile |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The bench builds the engine with its default parameters: a 16 x 16 tile capacity, 8-bit operands, 32-bit accumulators and 12-bit size fields. With these values a full-capacity 16x16x16 run fits well inside the run budget. A size of 17 can be encoded and must be rejected. The accumulator can be preloaded near 2^31 so that the modulo-2^32 wrap is exercised. Random operand and accumulator contents, with random sizes up to 6, are mixed with directed cases for zero and oversized dimensions, the K mismatch, the illegal opcode, the matrix-vector flag and commands or writes issued mid-run.

// File: rtl/tile_mma_pkg.sv
package tile_mma_pkg;

  typedef enum logic [1:0] {
    OP_FRESH = 2'd0,
    OP_ACCUM = 2'd1,
    OP_BIAS  = 2'd2,
    OP_BAD   = 2'd3
  } mmaOp_e;

  typedef enum logic [1:0] {
    SEL_LEFT  = 2'd0,
    SEL_RIGHT = 2'd1,
    SEL_ACC   = 2'd2,
    SEL_BIAS  = 2'd3
  } bufSel_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic   mac;    // one multiply-accumulate this cycle
    logic   first;  // k index is zero: start from the seed value
    logic   wr;     // last k: commit the sum to the accumulator
    mmaOp_e mode;
  } mmaCtl_t;

endpackage

// File: rtl/tile_mma_ctrl.sv
module tile_mma_ctrl
  import tile_mma_pkg::*;
#(
  parameter int DIM   = 16,
  parameter int DIM_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdValid,
  input  logic [1:0]                cmdOp,
  input  logic                      cmdGemv,
  input  logic [DIM_W-1:0]          cmdM,
  input  logic [DIM_W-1:0]          cmdK,
  input  logic [DIM_W-1:0]          cmdKr,
  input  logic [DIM_W-1:0]          cmdN,
  output mmaCtl_t                   ctl,
  output logic [$clog2(DIM)-1:0]    rowIdx,
  output logic [$clog2(DIM)-1:0]    colIdx,
  output logic [$clog2(DIM)-1:0]    kIdx,
  output logic                      busy,
  output logic                      done,
  output logic                      err
);

  localparam int IDX_W = $clog2(DIM);
  localparam int CNT_W = IDX_W + 1;

  logic             busyR, doneR, errR;
  logic [CNT_W-1:0] mLat, nLat, kLat;
  logic [IDX_W-1:0] iCnt, jCnt, kCnt;
  mmaOp_e           opLat;
  logic             accept, cmdLegal, lastK, lastJ, lastI;

  function automatic logic dimOk(input logic [DIM_W-1:0] d);
    return (d != '0) && (d <= DIM_W'(DIM));
  endfunction

  always_comb begin
    cmdLegal = (cmdOp != 2'(OP_BAD)) && dimOk(cmdM) && dimOk(cmdK)
               && dimOk(cmdN) && (cmdKr == cmdK)
               && !(cmdGemv && (cmdM != DIM_W'(1)));
    accept = cmdValid && !busyR;
    lastK  = (CNT_W'(kCnt) + CNT_W'(1)) == kLat;
    lastJ  = (CNT_W'(jCnt) + CNT_W'(1)) == nLat;
    lastI  = (CNT_W'(iCnt) + CNT_W'(1)) == mLat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR <= 1'b0;
      doneR <= 1'b0;
      errR  <= 1'b0;
      mLat  <= '0;
      nLat  <= '0;
      kLat  <= '0;
      iCnt  <= '0;
      jCnt  <= '0;
      kCnt  <= '0;
      opLat <= OP_FRESH;
    end else begin
      doneR <= 1'b0;
      errR  <= 1'b0;
      if (accept) begin
        if (cmdLegal) begin
          busyR <= 1'b1;
          mLat  <= CNT_W'(cmdM);
          nLat  <= CNT_W'(cmdN);
          kLat  <= CNT_W'(cmdK);
          iCnt  <= '0;
          jCnt  <= '0;
          kCnt  <= '0;
          opLat <= mmaOp_e'(cmdOp);
        end else begin
          errR <= 1'b1;
        end
      end else if (busyR) begin
        if (lastK) begin
          kCnt <= '0;
          if (lastJ) begin
            jCnt <= '0;
            if (lastI) begin
              busyR <= 1'b0;
              doneR <= 1'b1;
            end else begin
              iCnt <= iCnt + IDX_W'(1);
            end
          end else begin
            jCnt <= jCnt + IDX_W'(1);
          end
        end else begin
          kCnt <= kCnt + IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    ctl.mac   = busyR;
    ctl.first = (kCnt == '0);
    ctl.wr    = busyR && lastK;
    ctl.mode  = opLat;
  end

  assign rowIdx = iCnt;
  assign colIdx = jCnt;
  assign kIdx   = kCnt;
  assign busy   = busyR;
  assign done   = doneR;
  assign err    = errR;

  // R9: commits stay inside the latched valid region
  a_r9_write_in_region: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr |-> ((CNT_W'(iCnt) < mLat) && (CNT_W'(jCnt) < nLat)));

  // R4: done is a single-cycle pulse that follows the end of a run
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r4_done_after_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(busy) && !busy));

  // R8: a rejection never starts a run and lasts one cycle
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!busy && !$past(busy)));
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    err |=> !err);

  // R11: a command seen while busy leaves the latched shape unchanged
  a_r11_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> ($stable(mLat) && $stable(nLat) && $stable(kLat)));

endmodule

// File: rtl/tile_mma_dp.sv
module tile_mma_dp
  import tile_mma_pkg::*;
#(
  parameter int DIM   = 16,
  parameter int IN_W  = 8,
  parameter int ACC_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mmaCtl_t                   ctl,
  input  logic [$clog2(DIM)-1:0]    rowIdx,
  input  logic [$clog2(DIM)-1:0]    colIdx,
  input  logic [$clog2(DIM)-1:0]    kIdx,
  input  logic                      wrEn,
  input  logic [1:0]                wrSel,
  input  logic [$clog2(DIM)-1:0]    wrRow,
  input  logic [$clog2(DIM)-1:0]    wrCol,
  input  logic [ACC_W-1:0]          wrData,
  input  logic [$clog2(DIM)-1:0]    rdRow,
  input  logic [$clog2(DIM)-1:0]    rdCol,
  output logic [ACC_W-1:0]          rdData
);

  localparam int PROD_W = 2 * IN_W;

  logic [IN_W-1:0]  leftBuf  [DIM][DIM];
  logic [IN_W-1:0]  rightBuf [DIM][DIM];
  logic [ACC_W-1:0] accBuf   [DIM][DIM];
  logic [ACC_W-1:0] biasBuf  [DIM];
  logic [ACC_W-1:0] partial;

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prodExt, seedVal, baseVal, sumVal;

  always_comb begin
    prod    = $signed(leftBuf[rowIdx][kIdx]) * $signed(rightBuf[kIdx][colIdx]);
    prodExt = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    unique case (ctl.mode)
      OP_ACCUM: seedVal = accBuf[rowIdx][colIdx];
      OP_BIAS:  seedVal = biasBuf[colIdx];
      default:  seedVal = '0;
    endcase
    baseVal = ctl.first ? seedVal : partial;
    sumVal  = baseVal + prodExt;   // modulo 2^ACC_W
  end

  always_ff @(posedge clk) begin
    if (!rstN) partial <= '0;
    else if (ctl.mac) partial <= sumVal;
  end

  always_ff @(posedge clk) begin
    if (ctl.mac) begin
      if (ctl.wr) accBuf[rowIdx][colIdx] <= sumVal;
    end else if (wrEn) begin
      unique case (bufSel_e'(wrSel))
        SEL_LEFT:  leftBuf[wrRow][wrCol]  <= wrData[IN_W-1:0];
        SEL_RIGHT: rightBuf[wrRow][wrCol] <= wrData[IN_W-1:0];
        SEL_ACC:   accBuf[wrRow][wrCol]   <= wrData;
        default:   biasBuf[wrCol]         <= wrData;
      endcase
    end
  end

  assign rdData = accBuf[rdRow][rdCol];

  // R4: a commit only happens inside a multiply cycle
  a_r4_commit_in_mac: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr |-> ctl.mac);

  // R1: a chain continuing past k=0 builds on the previous cycle's partial sum
  a_r1_chain_continues: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mac && !ctl.first) |-> $past(ctl.mac));

endmodule

// File: rtl/tile_mma_engine.sv
module tile_mma_engine
  import tile_mma_pkg::*;
#(
  parameter int DIM   = 16,
  parameter int IN_W  = 8,
  parameter int ACC_W = 32,
  parameter int DIM_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [1:0]             wrSel,
  input  logic [$clog2(DIM)-1:0] wrRow,
  input  logic [$clog2(DIM)-1:0] wrCol,
  input  logic [ACC_W-1:0]       wrData,
  input  logic [$clog2(DIM)-1:0] rdRow,
  input  logic [$clog2(DIM)-1:0] rdCol,
  output logic [ACC_W-1:0]       rdData,
  input  logic                   cmdValid,
  input  logic [1:0]             cmdOp,
  input  logic                   cmdGemv,
  input  logic [DIM_W-1:0]       cmdM,
  input  logic [DIM_W-1:0]       cmdK,
  input  logic [DIM_W-1:0]       cmdKr,
  input  logic [DIM_W-1:0]       cmdN,
  output logic                   busy,
  output logic                   done,
  output logic                   err
);

  localparam int IDX_W = $clog2(DIM);

  mmaCtl_t          ctl;
  logic [IDX_W-1:0] rowIdx, colIdx, kIdx;

  tile_mma_ctrl #(.DIM(DIM), .DIM_W(DIM_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdGemv(cmdGemv), .cmdM(cmdM), .cmdK(cmdK), .cmdKr(cmdKr), .cmdN(cmdN),
    .ctl(ctl), .rowIdx(rowIdx), .colIdx(colIdx), .kIdx(kIdx),
    .busy(busy), .done(done), .err(err)
  );

  tile_mma_dp #(.DIM(DIM), .IN_W(IN_W), .ACC_W(ACC_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rowIdx(rowIdx), .colIdx(colIdx),
    .kIdx(kIdx), .wrEn(wrEn), .wrSel(wrSel), .wrRow(wrRow), .wrCol(wrCol),
    .wrData(wrData), .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData)
  );

endmodule

// File: tb/tb_tile_mma_engine.sv
`timescale 1ns/100ps
module tb_tile_mma_engine;

  localparam int DIM = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [3:0]  wrRow = '0, wrCol = '0, rdRow = '0, rdCol = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        cmdValid = 1'b0, cmdGemv = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic [11:0] cmdM = '0, cmdK = '0, cmdKr = '0, cmdN = '0;
  logic        busy, done, err;

  int total = 0;
  int bad = 0;

  logic signed [7:0] mL [DIM][DIM];
  logic signed [7:0] mR [DIM][DIM];
  int                mA [DIM][DIM];
  int                mB [DIM];

  always #2 clk = ~clk;

  tile_mma_engine dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrRow(wrRow),
    .wrCol(wrCol), .wrData(wrData), .rdRow(rdRow), .rdCol(rdCol),
    .rdData(rdData), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdGemv(cmdGemv),
    .cmdM(cmdM), .cmdK(cmdK), .cmdKr(cmdKr), .cmdN(cmdN),
    .busy(busy), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int sel, input int r, input int c, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'(sel); wrRow = 4'(r); wrCol = 4'(c); wrData = d;
    case (sel)
      0: mL[r][c] = d[7:0];
      1: mR[r][c] = d[7:0];
      2: mA[r][c] = d;
      default: mB[c] = d;
    endcase
  endtask

  task automatic endPut();
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkTile(input string req);
    int miss = 0;
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        rdRow = 4'(i); rdCol = 4'(j);
        #0.1;
        if (rdData !== mA[i][j]) begin
          if (miss == 0)
            $display("FAIL %s tile[%0d][%0d] actual=%h expected=%h",
                     req, i, j, rdData, mA[i][j]);
          miss++;
        end
      end
    total++;
    if (miss != 0) bad++;
  endtask

  function automatic void model(input int op, input int m, input int k, input int n);
    for (int i = 0; i < m; i++)
      for (int j = 0; j < n; j++) begin
        int s;
        s = (op == 1) ? mA[i][j] : (op == 2) ? mB[j] : 0;
        for (int q = 0; q < k; q++) s += int'(mL[i][q]) * int'(mR[q][j]);
        mA[i][j] = s;
      end
  endfunction

  task automatic issue(input int op, input bit gv, input int m, input int k,
                       input int kr, input int n);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdGemv = gv;
    cmdM = 12'(m); cmdK = 12'(k); cmdKr = 12'(kr); cmdN = 12'(n);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitRun(input int op, input int m, input int k, input int n,
                         input int preCycles, input string req);
    int cycles = preCycles;
    while (busy === 1'b1 && cycles < 6000) begin
      cycles++;
      @(negedge clk);
    end
    check(cycles == m * n * k, "R4", "busy cycles", cycles, m * n * k);
    check(done === 1'b1, "R4", "done at end", done, 1);
    @(negedge clk);
    check(done === 1'b0, "R4", "done one cycle", done, 0);
    model(op, m, k, n);
    checkTile(req);
  endtask

  task automatic runOk(input int op, input bit gv, input int m, input int k,
                       input int n, input string req);
    issue(op, gv, m, k, k, n);
    waitRun(op, m, k, n, 0, req);
  endtask

  task automatic runBad(input int op, input bit gv, input int m, input int k,
                        input int kr, input int n, input string req);
    issue(op, gv, m, k, kr, n);
    check(err === 1'b1 && busy === 1'b0, req, "err raised, busy low",
          {err, busy}, 2);
    @(negedge clk);
    check(err === 1'b0, "R8", "err one cycle", err, 0);
    checkTile({req, " R8 no write"});
  endtask

  task automatic fillOperands(input int span);
    for (int i = 0; i < span; i++)
      for (int j = 0; j < span; j++) begin
        put(0, i, j, $urandom);
        put(1, i, j, $urandom);
      end
    for (int j = 0; j < DIM; j++) put(3, 0, j, $urandom);
    endPut();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R12",
          "busy/done/err after reset", {busy, done, err}, 0);

    // full preload so untouched regions are meaningful (R9)
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        put(0, i, j, $urandom);
        put(1, i, j, $urandom);
        put(2, i, j, $urandom);
      end
    for (int j = 0; j < DIM; j++) put(3, 0, j, $urandom);
    endPut();

    // directed: fresh, accumulate, bias on a small shape
    runOk(0, 1'b0, 2, 3, 4, "R1 R9 fresh");
    runOk(1, 1'b0, 2, 3, 4, "R2 R9 accumulate");
    runOk(2, 1'b0, 3, 2, 5, "R3 R9 bias");
    // R5: matrix-vector form
    runOk(0, 1'b1, 1, 7, 9, "R5 gemv fresh");
    runBad(0, 1'b1, 2, 3, 3, 3, "R5 gemv with M=2");
    // R6: size limits
    runBad(0, 1'b0, 0, 3, 3, 3, "R6 M=0");
    runBad(1, 1'b0, 3, 3, 3, 17, "R6 N=17");
    runBad(2, 1'b0, 3, 20, 20, 3, "R6 K=20");
    runBad(0, 1'b0, 3, 3, 3, 4095, "R6 N=4095");
    // R7: shape and opcode legality
    runBad(0, 1'b0, 3, 4, 5, 3, "R7 K mismatch");
    runBad(3, 1'b0, 2, 2, 2, 2, "R7 opcode 3");
    // full capacity
    runOk(1, 1'b0, 16, 16, 16, "R2 full tile");

    // R10: wrap at 2^32
    put(2, 0, 0, 32'h7FFF_FFFF);
    put(0, 0, 0, 32'd1);
    put(1, 0, 0, 32'd1);
    endPut();
    runOk(1, 1'b0, 1, 1, 1, "R10 wrap");
    rdRow = '0; rdCol = '0;
    #0.1;
    check(rdData === 32'h8000_0000, "R10", "wrapped value", rdData, 32'h8000_0000);

    // R11: command and buffer write issued mid-run are ignored
    issue(0, 1'b0, 3, 3, 3, 3);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd1; cmdM = 12'd1; cmdK = 12'd1;
    cmdKr = 12'd1; cmdN = 12'd1;
    wrEn = 1'b1; wrSel = 2'd2; wrRow = 4'd15; wrCol = 4'd15; wrData = 32'hDEAD_BEEF;
    @(negedge clk);
    cmdValid = 1'b0; wrEn = 1'b0;
    waitRun(0, 3, 3, 3, 2, "R11 ignore while busy");
    check(busy === 1'b0, "R11", "no second run started", busy, 0);

    // random mixture
    for (int it = 0; it < 15; it++) begin
      int op, m, k, n;
      fillOperands(6);
      op = it % 3;
      m = 1 + int'($urandom % 6);
      k = 1 + int'($urandom % 6);
      n = 1 + int'($urandom % 6);
      case (op)
        0: runOk(op, 1'b0, m, k, n, "R1 random");
        1: runOk(op, 1'b0, m, k, n, "R2 random");
        default: runOk(op, 1'b0, m, k, n, "R3 random");
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule